// File: doc/BRIEF.md
# MDIO Management Frame Master

This block issues clause-22 management frames to an Ethernet PHY over the MDC/MDIO pair. The host launches a whole transaction with one 32-bit command write. The command word already holds every field that goes on the wire after the preamble. The block sends 32 ones as a preamble and then shifts the 32 command bits out, most significant bit first. MDC is produced from the system clock by a divider, so one MDC period lasts twice the programmed speed value in system cycles.

On a read frame the block releases the data line for the turnaround and data bit times. It samples the PHY's 16 data bits on the rising edges of MDC. At the end of the frame it places those bits in the low half of the command/data register. When any frame finishes, a sticky completion flag rises in the event word. The host clears it by writing a word with that bit position set.

The command input is a plain register write, not a handshake. A write that arrives while a frame is running is dropped, and the `busy` output tells the host when to retry. No data stream crosses the boundary, so there is no valid/ready port and no back-pressure.

Top module: `mdio_master`

## Requirements
- R1: After reset, `mdc`, `mdio_o`, `mdio_oe`, `busy` and `done_evt` are 0 and `rdata` is all zeros.
- R2: A `cmd_wr` pulse while idle stores `cmd_wdata` in `rdata` and raises `busy` in the next cycle. The frame starts at once, with no further control write.
- R3: While a frame runs, MDC stays low for `speed` cycles and then high for `speed` cycles, starting low. When `speed` is 0, MDC is held low and the frame does not advance until `speed` becomes nonzero. MDC is low whenever the block is idle.
- R4: A frame has 64 bit times. Bit times 0 to 31 carry 1. Bit time 32+j carries command bit 31-j. Each bit time begins as MDC falls (or at the start) and covers one full MDC period.
- R5: Command layout: [31:30] start code, [29:28] opcode, [27:23] PHY address, [22:18] register address, [17:16] turnaround, [15:0] data. Only opcode 2'b10 is a read. Any other opcode is sent as a write, and a write drives `mdio_oe` high for all 64 bit times.
- R6: A read frame drives `mdio_oe` low from bit time 46 (the turnaround) to the end of the frame. `mdio_oe` is low when idle, and `mdio_o` is 0 whenever `mdio_oe` is low.
- R7: In a read frame, `mdio_i` is sampled at the MDC rising edge of bit times 48 to 63, first bit as MSB. The 16 bits replace `rdata[15:0]` when the frame ends, and `rdata[31:16]` keeps the command.
- R8: A frame lasts exactly 128*`speed` cycles of `busy`. `busy` falls on the same clock edge as the final MDC fall, and `done_evt` rises on that same edge.
- R9: `done_evt` is sticky. An `evt_wr` with `evt_wdata[DONE_BIT]` = 1 clears it (DONE_BIT defaults to 23). A write with that bit at 0 leaves it set. A completion in the same cycle as a clear leaves it set.
- R10: A `cmd_wr` while `busy` is 1 is ignored: `rdata` and the frame in flight are unchanged.
- R11: `busy` is 1 from the cycle after an accepted command until the frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| speed | input | SPEED_W | MDC half-period in system cycles; 0 stops MDC |
| cmd_wr | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command word |
| evt_wr | input | 1 | Write strobe for the event word |
| evt_wdata | input | 32 | Event write data; a 1 at DONE_BIT clears the flag |
| rdata | output | 32 | Command/data register; low half holds read data after a read |
| busy | output | 1 | Frame in progress |
| done_evt | output | 1 | Sticky completion flag |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Output enable for the MDIO pad |
| mdio_i | input | 1 | Management data in from the pad |

## Verification
A wrong bit counter or divider state shows up within one MDC half-period. It appears on `mdc` or `mdio_o`, and the cycle-exact bench model compares both on every clock. An error in read/write decoding appears as a wrong `mdio_oe` level at bit time 46. An error in capture order appears in `rdata[15:0]` on the cycle the frame ends. A completion or event fault appears as a `busy` or `done_evt` edge one or more cycles away from 128*`speed` cycles after the start.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int WORD_W  = 32;
  localparam int DATA_W  = 16;
  localparam int PRE_LEN = 32;
  localparam int OP_HI   = 29;
  localparam int OP_LO   = 28;
  localparam int TA_HI   = 17;

  typedef enum logic [1:0] {
    OP_WR = 2'b01,
    OP_RD = 2'b10
  } mdio_op_e;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int SPEED_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [SPEED_W-1:0] speed,
  output logic               mdc,
  output logic               rise,
  output logic               fall
);
  logic [SPEED_W-1:0] cnt;
  logic               mdc_q;
  logic               active;
  logic               wrap;

  assign active = run && (speed != '0);
  assign wrap   = active && (cnt == speed - SPEED_W'(1));
  assign rise   = wrap && !mdc_q;
  assign fall   = wrap && mdc_q;
  assign mdc    = mdc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      mdc_q <= 1'b0;
    end else if (!active) begin
      cnt   <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt   <= '0;
      mdc_q <= !mdc_q;
    end else begin
      cnt <= cnt + SPEED_W'(1);
    end
  end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] word,
  input  logic              rise,
  input  logic              fall,
  input  logic              mdio_i,
  output logic              busy,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic              rd_done,
  output logic [DATA_W-1:0] rd_data
);
  localparam int FRAME_LEN = PRE_LEN + WORD_W;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int WSEL_W    = $clog2(WORD_W);
  localparam int LAST_IDX  = FRAME_LEN - 1;
  localparam int TA_IDX    = PRE_LEN + WORD_W - 1 - TA_HI;
  localparam int DAT_IDX   = FRAME_LEN - DATA_W;

  logic [WORD_W-1:0] word_q;
  logic [IDX_W-1:0]  idx;
  logic              busy_q;
  logic              rd_q;
  logic [DATA_W-1:0] sh;
  logic [WSEL_W-1:0] wsel;
  logic              cur_bit;
  logic              at_last;

  assign wsel    = WSEL_W'(LAST_IDX - int'(idx));
  assign cur_bit = (int'(idx) < PRE_LEN) ? 1'b1 : word_q[wsel];
  assign at_last = (int'(idx) == LAST_IDX);
  assign mdio_oe = busy_q && !(rd_q && int'(idx) >= TA_IDX);
  assign mdio_o  = mdio_oe && cur_bit;
  assign done    = busy_q && fall && at_last;
  assign rd_done = done && rd_q;
  assign busy    = busy_q;
  assign rd_data = sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      idx    <= '0;
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      sh     <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        idx    <= '0;
        word_q <= word;
        rd_q   <= (word[OP_HI:OP_LO] == OP_RD);
      end
    end else begin
      if (rise && rd_q && int'(idx) >= DAT_IDX)
        sh <= {sh[DATA_W-2:0], mdio_i};
      if (fall) begin
        if (at_last) busy_q <= 1'b0;
        else         idx    <= idx + IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/mdio_evt_reg.sv
module mdio_evt_reg #(
  parameter int DONE_BIT = 23
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        set,
  input  logic        wr,
  input  logic [31:0] wdata,
  output logic        flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)                   flag <= 1'b0;
    else if (set)                 flag <= 1'b1;
    else if (wr && wdata[DONE_BIT]) flag <= 1'b0;
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int SPEED_W  = 8,
  parameter int DONE_BIT = 23
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SPEED_W-1:0] speed,
  input  logic               cmd_wr,
  input  logic [31:0]        cmd_wdata,
  input  logic               evt_wr,
  input  logic [31:0]        evt_wdata,
  output logic [31:0]        rdata,
  output logic               busy,
  output logic               done_evt,
  output logic               mdc,
  output logic               mdio_o,
  output logic               mdio_oe,
  input  logic               mdio_i
);
  logic              rise, fall, done, rd_done;
  logic [DATA_W-1:0] rd_data;
  logic [31:0]       cmd_q;

  mdio_clkdiv #(.SPEED_W(SPEED_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .speed(speed),
    .mdc(mdc), .rise(rise), .fall(fall)
  );

  mdio_frame_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(cmd_wr), .word(cmd_wdata),
    .rise(rise), .fall(fall), .mdio_i(mdio_i), .busy(busy),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .done(done),
    .rd_done(rd_done), .rd_data(rd_data)
  );

  mdio_evt_reg #(.DONE_BIT(DONE_BIT)) u_evt (
    .clk(clk), .rst_n(rst_n), .set(done), .wr(evt_wr),
    .wdata(evt_wdata), .flag(done_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                cmd_q <= '0;
    else if (cmd_wr && !busy)  cmd_q <= cmd_wdata;
    else if (rd_done)          cmd_q[DATA_W-1:0] <= rd_data;
  end

  assign rdata = cmd_q;
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int SPEED_W  = 8,
  parameter int DONE_BIT = 23
) (
  input logic               clk,
  input logic               rst_n,
  input logic [SPEED_W-1:0] speed,
  input logic               cmd_wr,
  input logic               evt_wr,
  input logic [31:0]        evt_wdata,
  input logic [31:0]        rdata,
  input logic               busy,
  input logic               done_evt,
  input logic               mdc,
  input logic               mdio_o,
  input logic               mdio_oe
);
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy) |=> busy);
  p_mdc_idle_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);
  p_mdc_needs_speed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> ($past(speed) != '0));
  p_oe_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);
  p_out_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mdio_oe |-> !mdio_o);
  p_end_sets_evt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_evt);
  p_evt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && !(evt_wr && evt_wdata[DONE_BIT])) |=> done_evt);
  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && busy) |=> $stable(rdata[31:16]));
endmodule

bind mdio_master mdio_master_chk #(.SPEED_W(SPEED_W), .DONE_BIT(DONE_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .speed(speed), .cmd_wr(cmd_wr),
  .evt_wr(evt_wr), .evt_wdata(evt_wdata), .rdata(rdata), .busy(busy),
  .done_evt(done_evt), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  localparam int SPEED_W  = 8;
  localparam int DONE_BIT = 23;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [SPEED_W-1:0] speed = '0;
  logic               cmd_wr = 1'b0;
  logic [31:0]        cmd_wdata = '0;
  logic               evt_wr = 1'b0;
  logic [31:0]        evt_wdata = '0;
  logic [31:0]        rdata;
  logic               busy, done_evt, mdc, mdio_o, mdio_oe;
  logic               mdio_i = 1'b1;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // behavioural reference state
  int          k = 0;
  bit          m_busy = 0, m_evt = 0, m_rd = 0;
  logic [31:0] m_cmd = '0, m_reg = '0;
  logic [15:0] phy_data = '0;

  always #2.5 clk = !clk;

  mdio_master #(.SPEED_W(SPEED_W), .DONE_BIT(DONE_BIT)) dut (
    .clk(clk), .rst_n(rst_n), .speed(speed), .cmd_wr(cmd_wr),
    .cmd_wdata(cmd_wdata), .evt_wr(evt_wr), .evt_wdata(evt_wdata),
    .rdata(rdata), .busy(busy), .done_evt(done_evt), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // reference model update on each clock edge
  always @(posedge clk) begin
    if (!rst_n) begin
      k = 0; m_busy = 0; m_evt = 0; m_rd = 0; m_cmd = '0; m_reg = '0;
    end else begin
      bit set_e;
      set_e = 0;
      if (m_busy) begin
        if (speed != 0) k++;
        if (speed != 0 && k == 128 * int'(speed)) begin
          m_busy = 0;
          set_e  = 1;
          if (m_rd) m_reg[15:0] = phy_data;
        end
      end else if (cmd_wr) begin
        m_busy = 1; k = 0; m_cmd = cmd_wdata; m_reg = cmd_wdata;
        m_rd = (cmd_wdata[29:28] == 2'b10);
      end
      if (set_e) m_evt = 1;
      else if (evt_wr && evt_wdata[DONE_BIT]) m_evt = 0;
    end
  end

  // per-cycle comparison and PHY model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int s, idx;
      bit e_mdc, e_oe, e_o;
      s   = int'(speed);
      idx = (s == 0) ? 0 : k / (2 * s);
      e_mdc = m_busy && s != 0 && ((k / s) % 2 == 1);
      e_oe  = m_busy && !(m_rd && idx >= 46);
      e_o   = e_oe && ((idx < 32) ? 1'b1 : m_cmd[63 - idx]);
      chk("R3 mdc", {31'd0, mdc}, {31'd0, e_mdc});
      chk("R6 mdio_oe", {31'd0, mdio_oe}, {31'd0, e_oe});
      chk("R4 mdio_o", {31'd0, mdio_o}, {31'd0, e_o});
      chk("R11 busy", {31'd0, busy}, {31'd0, m_busy});
      chk("R9 done_evt", {31'd0, done_evt}, {31'd0, m_evt});
      chk("R7 rdata", rdata, m_reg);
      mdio_i <= (m_busy && m_rd && idx >= 48) ? phy_data[63 - idx] : 1'b1;
    end
  end

  task automatic send_cmd(input logic [31:0] w);
    @(negedge clk);
    cmd_wr = 1'b1; cmd_wdata = w;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic evt_write(input logic [31:0] w);
    @(negedge clk);
    evt_wr = 1'b1; evt_wdata = w;
    @(negedge clk);
    evt_wr = 1'b0; evt_wdata = '0;
  endtask

  // counts busy cycles from the negedge after the command
  task automatic wait_done(output int n);
    n = 1;
    while (busy && n < 50000) begin
      @(negedge clk);
      if (busy) n++;
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1 mdc", {31'd0, mdc}, 32'd0);
    chk("R1 oe", {31'd0, mdio_oe}, 32'd0);
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 evt", {31'd0, done_evt}, 32'd0);
    chk("R1 rdata", rdata, 32'd0);
    rst_n = 1'b1;

    // write frame, speed 2
    speed = 8'd2;
    send_cmd({2'b01, 2'b01, 5'd3, 5'd4, 2'b10, 16'hA5C3});
    chk("R2 busy after accept", {31'd0, busy}, 32'd1);
    chk("R2 rdata holds command", rdata, {2'b01, 2'b01, 5'd3, 5'd4, 2'b10, 16'hA5C3});
    wait_done(n);
    chk("R8 frame length speed 2", n, 32'd256);
    chk("R8 evt at end", {31'd0, done_evt}, 32'd1);

    // event clear rules
    evt_write(32'h0000_0001);
    chk("R9 other bit keeps evt", {31'd0, done_evt}, 32'd1);
    evt_write(32'h1 << DONE_BIT);
    chk("R9 clear by bit", {31'd0, done_evt}, 32'd0);

    // read frame, speed 3, with an ignored write mid-frame
    speed = 8'd3;
    phy_data = 16'hBEEF;
    send_cmd({2'b01, 2'b10, 5'd1, 5'd2, 2'b11, 16'h0000});
    repeat (40) @(negedge clk);
    send_cmd(32'hFFFF_FFFF);
    chk("R10 rdata unchanged", rdata, {2'b01, 2'b10, 5'd1, 5'd2, 2'b11, 16'h0000});
    wait_done(n);
    chk("R8 frame length speed 3", n, 32'd384 - 32'd42);
    @(negedge clk);
    chk("R7 read data", rdata, {2'b01, 2'b10, 5'd1, 5'd2, 2'b11, 16'hBEEF});

    // opcode 11 treated as write, speed 1
    speed = 8'd1;
    send_cmd({2'b01, 2'b11, 5'd31, 5'd0, 2'b10, 16'h1234});
    wait_done(n);
    chk("R5 opcode 11 drives full frame", rdata[15:0], 32'h1234);

    // speed 0 stalls, then resumes
    speed = 8'd0;
    send_cmd({2'b01, 2'b01, 5'd7, 5'd9, 2'b10, 16'h0F0F});
    repeat (20) @(negedge clk);
    chk("R3 mdc low at speed 0", {31'd0, mdc}, 32'd0);
    chk("R3 frame stalled at speed 0", {31'd0, busy}, 32'd1);
    speed = 8'd1;
    wait_done(n);
    chk("R8 frame ends after resume", {31'd0, busy}, 32'd0);
    repeat (4) @(negedge clk);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule